// File: doc/BRIEF.md
# Legacy System I/O Control Register Block

This block sits on a byte-wide I/O-port bus and serves a fixed set of legacy system-control ports. The bus has an address, a read strobe, a write strobe, write data and combinational read data. Three ports hold state.

- A soft-reset port drives a soft-reset level output. A bit on the same port that asks for an unsupported byte order raises a sticky error flag.
- A system-control port keeps four inhibit and mask bits.
- A map-type port drives the non-contiguous I/O map output. It comes out of reset with that mode selected.

Two read-only ports return strap values fixed at build time: the equipment strap and the board identifier. A keylock port always reads zero. Four write-only ports accept writes and change nothing. These are the indicator light, two password ports and the cache-invalidate port.

Register bits use most-significant-first numbering. Bit n of a byte has weight 1 << (7 - n), so bit 7 is the value 0x01.

A second, separate 32-bit memory-mapped port answers a parity-status word. The word always reads zero. Only full, aligned 32-bit reads of it are legal.

Top module: `sysio_ctl`

## Requirements
- R1: A write to port 0x092 stores only bit 7 (value 0x01), the soft-reset bit. A read of 0x092 returns that bit with all other bits 0. soft_reset_o follows the stored bit from the clock edge that takes the write.
- R2: Writing 0x092 with bit 6 (value 0x02) set raises le_err_o from the next edge. le_err_o stays high until reset. The bit is never stored, so it never reads back.
- R3: A write to port 0x81C keeps bits 0 to 3 (mask 0xF0) and discards the rest. A read of 0x81C returns the masked value.
- R4: A write to port 0x850 keeps only bit 7 (value 0x01). The same edge updates noncontig_map_o to that bit. A read of 0x850 returns the stored value.
- R5: After reset, port 0x850 reads 0x01 and noncontig_map_o is 1. Port 0x092 reads 0x00 and soft_reset_o is 0. Port 0x81C reads 0x00 and le_err_o is 0.
- R6: Port 0x80C returns the parameter EQUIP_STRAP and port 0x852 returns the parameter BOARD_ID. Both parameters default to 0. Writes to these two ports are ignored.
- R7: Port 0x818 always reads 0x00.
- R8: Writes to ports 0x808, 0x810, 0x812 and 0x814 change no output and no readable register. Reads of these ports return 0xFF.
- R9: Reads of undecoded ports return 0xFF, and io_rdata is 0xFF whenever io_rd is low. Writes to undecoded ports are ignored.
- R10: A read at PARITY_BASE (default 0xBFFFEFF0) with all four byte enables set asserts mm_ack, leaves mm_err low and returns 0 on mm_rdata.
- R11: A read that hits the parity word but has a byte-enable pattern other than 0xF, or a nonzero address[1:0], asserts both mm_ack and mm_err. A read outside the word asserts neither.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | ADDR_W | I/O port address |
| io_rd | input | 1 | I/O read strobe |
| io_wr | input | 1 | I/O write strobe |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data, combinational |
| mm_addr | input | 32 | Memory-mapped byte address |
| mm_rd | input | 1 | Memory-mapped read strobe |
| mm_be | input | 4 | Memory-mapped byte enables |
| mm_ack | output | 1 | Access hits the parity word |
| mm_err | output | 1 | Hit with an illegal size or alignment |
| mm_rdata | output | 32 | Parity word read data |
| soft_reset_o | output | 1 | Soft-reset level |
| noncontig_map_o | output | 1 | Non-contiguous I/O map selected |
| le_err_o | output | 1 | Sticky unsupported byte-order request |

## Verification
A wrong value held in the soft-reset or map-type register shows on its output pin at the first edge after the write. The register itself can also be read back on the same bus on the very next cycle.

A mask error on the system-control port only appears on a read. It could therefore stay hidden until the port is read. For that reason the random mix reads back after most writes.

A decode slip shows up in one of two ways. A write to a write-only or read-only port may disturb a stored register, which a later read or pin reveals. Or a read returns a strap, a register or 0xFF where a different one was due.

// File: rtl/sysio_pkg.sv
package sysio_pkg;

    localparam int BYTE_W = 8;

    // Most-significant-first bit numbering: bit n has weight 1 << (7 - n)
    function automatic logic [BYTE_W-1:0] msb0_bit(input int n);
        return BYTE_W'(1) << (BYTE_W - 1 - n);
    endfunction

    localparam logic [BYTE_W-1:0] SRST_BIT    = msb0_bit(7);
    localparam logic [BYTE_W-1:0] LE_REQ_BIT  = msb0_bit(6);
    localparam logic [BYTE_W-1:0] SYSCTL_MASK = msb0_bit(0) | msb0_bit(1) |
                                                msb0_bit(2) | msb0_bit(3);
    localparam logic [BYTE_W-1:0] MAP_BIT     = msb0_bit(7);
    localparam logic [BYTE_W-1:0] FLOAT_BUS   = '1;

    localparam logic [15:0] A_SRST    = 16'h0092;
    localparam logic [15:0] A_LIGHT   = 16'h0808;
    localparam logic [15:0] A_EQUIP   = 16'h080C;
    localparam logic [15:0] A_PASS1   = 16'h0810;
    localparam logic [15:0] A_PASS2   = 16'h0812;
    localparam logic [15:0] A_L2INV   = 16'h0814;
    localparam logic [15:0] A_KEYLOCK = 16'h0818;
    localparam logic [15:0] A_SYSCTL  = 16'h081C;
    localparam logic [15:0] A_MAPTYPE = 16'h0850;
    localparam logic [15:0] A_BOARD   = 16'h0852;

    typedef enum logic [3:0] {
        P_NONE, P_SRST, P_LIGHT, P_EQUIP, P_PASS1, P_PASS2,
        P_L2INV, P_KEYLOCK, P_SYSCTL, P_MAPTYPE, P_BOARD
    } port_e;

    typedef struct packed {
        logic [BYTE_W-1:0] srst;
        logic [BYTE_W-1:0] sysctl;
        logic [BYTE_W-1:0] maptype;
    } regs_t;

    function automatic port_e decode_port(input logic [15:0] a);
        case (a)
            A_SRST:    return P_SRST;
            A_LIGHT:   return P_LIGHT;
            A_EQUIP:   return P_EQUIP;
            A_PASS1:   return P_PASS1;
            A_PASS2:   return P_PASS2;
            A_L2INV:   return P_L2INV;
            A_KEYLOCK: return P_KEYLOCK;
            A_SYSCTL:  return P_SYSCTL;
            A_MAPTYPE: return P_MAPTYPE;
            A_BOARD:   return P_BOARD;
            default:   return P_NONE;
        endcase
    endfunction

    function automatic logic is_write_only(input port_e p);
        return (p == P_LIGHT) || (p == P_PASS1) || (p == P_PASS2) || (p == P_L2INV);
    endfunction

endpackage

// File: rtl/sysio_decode.sv
module sysio_decode
    import sysio_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] addr,
    output port_e             port
);
    localparam int PAD_W = (ADDR_W > 16) ? ADDR_W - 16 : 1;

    logic [15:0] addr16;

    generate
        if (ADDR_W > 16) begin : g_wide
            logic [PAD_W-1:0] upper;
            assign upper  = addr[ADDR_W-1:16];
            assign addr16 = (upper == '0) ? addr[15:0] : 16'hFFFF;
        end else begin : g_narrow
            assign addr16 = 16'(addr);
        end
    endgenerate

    assign port = decode_port(addr16);
endmodule

// File: rtl/sysio_regs.sv
module sysio_regs
    import sysio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  port_e             port,
    input  logic [BYTE_W-1:0] wdata,
    output regs_t             q,
    output logic              le_err
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q.srst    <= '0;
            q.sysctl  <= '0;
            q.maptype <= MAP_BIT;
            le_err    <= 1'b0;
        end else if (wr) begin
            case (port)
                P_SRST: begin
                    q.srst <= wdata & SRST_BIT;
                    if ((wdata & LE_REQ_BIT) != '0) le_err <= 1'b1;
                end
                P_SYSCTL:  q.sysctl  <= wdata & SYSCTL_MASK;
                P_MAPTYPE: q.maptype <= wdata & MAP_BIT;
                default: ;
            endcase
        end
    end

    AST_SRST_LOAD: assert property (@(posedge clk) disable iff (rst)
        (wr && port == P_SRST) |=> (q.srst == ($past(wdata) & SRST_BIT))); // R1

    AST_LE_STICKY: assert property (@(posedge clk) disable iff (rst)
        le_err |=> le_err); // R2

    AST_MAP_LOAD: assert property (@(posedge clk) disable iff (rst)
        (wr && port == P_MAPTYPE) |=> (q.maptype == ($past(wdata) & MAP_BIT))); // R4

    AST_SRST_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(wr && port == P_SRST) |=> $stable(q.srst)); // R8
endmodule

// File: rtl/sysio_rdmux.sv
module sysio_rdmux
    import sysio_pkg::*;
#(
    parameter logic [7:0] EQUIP_STRAP = 8'h00,
    parameter logic [7:0] BOARD_ID    = 8'h00
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd,
    input  port_e             port,
    input  regs_t             q,
    output logic [BYTE_W-1:0] rdata
);
    always_comb begin
        rdata = FLOAT_BUS;
        if (rd) begin
            case (port)
                P_SRST:    rdata = q.srst;
                P_EQUIP:   rdata = EQUIP_STRAP;
                P_KEYLOCK: rdata = '0;
                P_SYSCTL:  rdata = q.sysctl;
                P_MAPTYPE: rdata = q.maptype;
                P_BOARD:   rdata = BOARD_ID;
                default:   rdata = FLOAT_BUS;
            endcase
        end
    end

    AST_SYSCTL_LOW_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (rd && port == P_SYSCTL) |-> ((rdata & ~SYSCTL_MASK) == '0)); // R3

    AST_SRST_READ_CLEAN: assert property (@(posedge clk) disable iff (rst)
        (rd && port == P_SRST) |-> ((rdata & ~SRST_BIT) == '0)); // R1

    AST_WO_FLOATS: assert property (@(posedge clk) disable iff (rst)
        (rd && is_write_only(port)) |-> (rdata == FLOAT_BUS)); // R8
endmodule

// File: rtl/sysio_mmio.sv
module sysio_mmio #(
    parameter logic [31:0] PARITY_BASE = 32'hBFFF_EFF0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] addr,
    input  logic        rd,
    input  logic [3:0]  be,
    output logic        ack,
    output logic        err,
    output logic [31:0] rdata
);
    localparam logic [29:0] WORD_IDX = PARITY_BASE[31:2];

    logic hit;

    assign hit   = rd && (addr[31:2] == WORD_IDX);
    assign ack   = hit;
    assign err   = hit && ((be != 4'hF) || (addr[1:0] != 2'b00));
    assign rdata = '0;

    AST_MM_ERR_NEEDS_ACK: assert property (@(posedge clk) disable iff (rst)
        err |-> ack); // R11

    AST_MM_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !rd |-> (!ack && !err)); // R11
endmodule

// File: rtl/sysio_ctl.sv
module sysio_ctl
    import sysio_pkg::*;
#(
    parameter int          ADDR_W      = 16,
    parameter logic [7:0]  EQUIP_STRAP = 8'h00,
    parameter logic [7:0]  BOARD_ID    = 8'h00,
    parameter logic [31:0] PARITY_BASE = 32'hBFFF_EFF0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_rd,
    input  logic              io_wr,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        io_rdata,
    input  logic [31:0]       mm_addr,
    input  logic              mm_rd,
    input  logic [3:0]        mm_be,
    output logic              mm_ack,
    output logic              mm_err,
    output logic [31:0]       mm_rdata,
    output logic              soft_reset_o,
    output logic              noncontig_map_o,
    output logic              le_err_o
);
    port_e port;
    regs_t q;

    sysio_decode #(.ADDR_W(ADDR_W)) i_decode (
        .addr (io_addr),
        .port (port)
    );

    sysio_regs i_regs (
        .clk    (clk),
        .rst    (rst),
        .wr     (io_wr),
        .port   (port),
        .wdata  (io_wdata),
        .q      (q),
        .le_err (le_err_o)
    );

    sysio_rdmux #(.EQUIP_STRAP(EQUIP_STRAP), .BOARD_ID(BOARD_ID)) i_rdmux (
        .clk   (clk),
        .rst   (rst),
        .rd    (io_rd),
        .port  (port),
        .q     (q),
        .rdata (io_rdata)
    );

    sysio_mmio #(.PARITY_BASE(PARITY_BASE)) i_mmio (
        .clk   (clk),
        .rst   (rst),
        .addr  (mm_addr),
        .rd    (mm_rd),
        .be    (mm_be),
        .ack   (mm_ack),
        .err   (mm_err),
        .rdata (mm_rdata)
    );

    assign soft_reset_o    = (q.srst & SRST_BIT) != '0;
    assign noncontig_map_o = (q.maptype & MAP_BIT) != '0;

    AST_MAP_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (noncontig_map_o && !soft_reset_o && !le_err_o)); // R5

    AST_KEYLOCK_ZERO: assert property (@(posedge clk) disable iff (rst)
        (io_rd && io_addr == ADDR_W'(16'h0818)) |-> (io_rdata == 8'h00)); // R7

    AST_IDLE_FLOAT: assert property (@(posedge clk) disable iff (rst)
        !io_rd |-> (io_rdata == 8'hFF)); // R9
endmodule

// File: tb/test_sysio_ctl.sv
module test_sysio_ctl;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] EQ = 8'hA5;
    localparam logic [7:0] BID = 8'h3C;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [15:0] io_addr = '0;
    logic io_rd = 1'b0, io_wr = 1'b0;
    logic [7:0] io_wdata = '0, io_rdata;
    logic [31:0] mm_addr = '0, mm_rdata;
    logic mm_rd = 1'b0, mm_ack, mm_err;
    logic [3:0] mm_be = '0;
    logic soft_reset_o, noncontig_map_o, le_err_o;

    int total = 0, bad = 0;
    logic [7:0] m_srst, m_sys, m_map;
    logic m_le;
    logic [7:0] got;

    always #(CLK_PERIOD/2) clk = ~clk;

    sysio_ctl #(.ADDR_W(16), .EQUIP_STRAP(EQ), .BOARD_ID(BID)) i_sysio_ctl (
        .clk(clk), .rst(rst), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .mm_addr(mm_addr), .mm_rd(mm_rd),
        .mm_be(mm_be), .mm_ack(mm_ack), .mm_err(mm_err), .mm_rdata(mm_rdata),
        .soft_reset_o(soft_reset_o), .noncontig_map_o(noncontig_map_o), .le_err_o(le_err_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_read(input logic [15:0] a);
        case (a)
            16'h0092: return m_srst;
            16'h080C: return EQ;
            16'h0818: return 8'h00;
            16'h081C: return m_sys;
            16'h0850: return m_map;
            16'h0852: return BID;
            default:  return 8'hFF;
        endcase
    endfunction

    function automatic string req_of(input logic [15:0] a);
        case (a)
            16'h0092: return "R1";
            16'h080C, 16'h0852: return "R6";
            16'h0818: return "R7";
            16'h081C: return "R3";
            16'h0850: return "R4";
            16'h0808, 16'h0810, 16'h0812, 16'h0814: return "R8";
            default:  return "R9";
        endcase
    endfunction

    task automatic model_write(input logic [15:0] a, input logic [7:0] d);
        case (a)
            16'h0092: begin m_srst = d & 8'h01; if (d[1]) m_le = 1'b1; end
            16'h081C: m_sys = d & 8'hF0;
            16'h0850: m_map = d & 8'h01;
            default: ;
        endcase
    endtask

    task automatic io_write(input logic [15:0] a, input logic [7:0] d);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
        model_write(a, d);
    endtask

    task automatic io_read(input logic [15:0] a, output logic [7:0] v);
        io_addr = a; io_rd = 1'b1;
        #1 v = io_rdata;
        @(negedge clk);
        io_rd = 1'b0;
    endtask

    task automatic chk_pins(input string req);
        chk({req, " soft_reset_o"}, 32'(soft_reset_o), 32'(m_srst[0]));
        chk({req, " noncontig_map_o"}, 32'(noncontig_map_o), 32'(m_map[0]));
        chk({req, " le_err_o"}, 32'(le_err_o), 32'(m_le));
    endtask

    task automatic rd_chk(input logic [15:0] a);
        io_read(a, got);
        chk(req_of(a), 32'(got), 32'(exp_read(a)));
    endtask

    task automatic mm_chk(input logic [31:0] a, input logic [3:0] be,
                          input logic e_ack, input logic e_err, input string req);
        mm_addr = a; mm_be = be; mm_rd = 1'b1;
        #1;
        chk({req, " ack"}, 32'(mm_ack), 32'(e_ack));
        chk({req, " err"}, 32'(mm_err), 32'(e_err));
        chk({req, " data"}, mm_rdata, 32'h0);
        @(negedge clk);
        mm_rd = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    localparam logic [15:0] CANDS [14] = '{16'h0092, 16'h0808, 16'h080C, 16'h0810,
        16'h0812, 16'h0814, 16'h0818, 16'h081C, 16'h0850, 16'h0852,
        16'h0093, 16'h0851, 16'h0000, 16'hF81C};

    initial begin
        void'($urandom(32'd7081));
        m_srst = 8'h00; m_sys = 8'h00; m_map = 8'h01; m_le = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R5 reset state
        chk_pins("R5");
        io_read(16'h0850, got); chk("R5 map reg", 32'(got), 32'h01);
        io_read(16'h0092, got); chk("R5 srst reg", 32'(got), 32'h00);
        io_read(16'h081C, got); chk("R5 sysctl reg", 32'(got), 32'h00);
        #1 chk("R9 idle bus", 32'(io_rdata), 32'hFF);

        // R1 soft reset bit, other bits dropped
        io_write(16'h0092, 8'hFD); chk_pins("R1");
        rd_chk(16'h0092);
        io_write(16'h0092, 8'h00); chk_pins("R1 clear");
        // R2 byte order request
        io_write(16'h0092, 8'h02); chk_pins("R2");
        io_read(16'h0092, got); chk("R2 not stored", 32'(got), 32'h00);
        // R3 mask
        io_write(16'h081C, 8'hFF); rd_chk(16'h081C);
        io_write(16'h081C, 8'h5A); rd_chk(16'h081C);
        // R4 map bit
        io_write(16'h0850, 8'hFE); chk_pins("R4 cleared"); rd_chk(16'h0850);
        io_write(16'h0850, 8'h01); chk_pins("R4 set");
        // R6 straps ignore writes
        io_write(16'h080C, 8'h00); rd_chk(16'h080C);
        io_write(16'h0852, 8'hFF); rd_chk(16'h0852);
        // R7
        rd_chk(16'h0818);
        // R8 write-only ports
        io_write(16'h0808, 8'hFF); io_write(16'h0810, 8'hFF);
        io_write(16'h0812, 8'h00); io_write(16'h0814, 8'hFF);
        chk_pins("R8"); rd_chk(16'h081C); rd_chk(16'h0810);
        // R9 undecoded
        io_write(16'h0093, 8'hFF); chk_pins("R9"); rd_chk(16'h0093);

        // R10/R11 memory-mapped word
        mm_chk(32'hBFFF_EFF0, 4'hF, 1'b1, 1'b0, "R10");
        mm_chk(32'hBFFF_EFF0, 4'h3, 1'b1, 1'b1, "R11 partial");
        mm_chk(32'hBFFF_EFF2, 4'hF, 1'b1, 1'b1, "R11 misaligned");
        mm_chk(32'hBFFF_EFF4, 4'hF, 1'b0, 1'b0, "R11 outside");

        // random mix
        for (int i = 0; i < 400; i++) begin
            logic [15:0] a;
            a = CANDS[$urandom_range(13, 0)];
            if ($urandom_range(1, 0) == 1) begin
                io_write(a, 8'($urandom));
                chk_pins(req_of(a));
            end
            rd_chk(a);
        end

        // reset again restores R5 state
        rst = 1'b1; @(negedge clk); rst = 1'b0;
        m_srst = 8'h00; m_sys = 8'h00; m_map = 8'h01; m_le = 1'b0;
        @(negedge clk);
        chk_pins("R5 rerun");
        rd_chk(16'h0850);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule